// File: doc/BRIEF.md
# Quad DAC Double-Buffered Code Register Bank

This block stores the conversion codes for a four-channel digital-to-analog converter. Each channel has two registers: a staging register, written by a serial receiver in front of the block, and an output register whose value goes to the converter. A write request carries a valid strobe, a two-bit channel number and an N-bit code, and it lands only in the staging register of that channel.

An active-low load strobe moves codes from staging to output. It is level-sensitive: while it is low, all four output registers follow their staging registers, and they all change on the same clock edge. While it is high, the outputs hold. The strobe is resynchronized to the block clock before use. Tying it low gives single-buffered operation, where each write reaches its output on the edge that stores it.

An active-low clear input, and the synchronous system reset used for power-on, force every staging and output register to a preset value. A select input picks that value: either all zeros, or half-scale, where only the most significant bit is set. The clear takes hold as soon as it is asserted and releases in step with the clock.

Top module: `quad_dac_regbank`

## Requirements
- R1: While `rst` is high, every staging and output register is loaded with the preset value on each clock edge. After `rst` falls, all four `dac_codes` lanes show that preset value.
- R2: With `half_sel` = 0 the preset value is zero. With `half_sel` = 1 only bit W-1 is set: 0x8000 when W = 16, 0x2000 when W = 14, 0x8 when W = 4.
- R3: A write with `wr_valid` = 1 stores `wr_data` only in the staging register chosen by `wr_addr`, where 0..3 select lanes 0..3 of `dac_codes` (lane k is bits k*W+W-1 down to k*W). The other staging registers keep their values.
- R4: After `ldac_n` goes low, the output registers take the staging contents on the (SYNC_STAGES+1)-th rising edge, and all four lanes change on that same edge. Before that edge the outputs are unchanged.
- R5: While the synchronized load strobe is high, the output registers hold their values, even across writes.
- R6: While the synchronized load strobe is low, a write reaches its output lane on the same edge that stores it in staging, which is single-buffered operation.
- R7: When `clr_n` goes low, the next edge presets all registers, and this repeats on every edge while `clr_n` stays low. Writes during that time are ignored. Writes are accepted again from the (SYNC_STAGES+1)-th edge after `clr_n` rises.
- R8: After a preset, the outputs keep the preset value until a write is followed by a load. A load with no write first leaves the preset value in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high system (power-on) reset |
| wr_valid | input | 1 | Write request strobe |
| wr_addr | input | 2 | Channel number of the write |
| wr_data | input | W | Code to store |
| ldac_n | input | 1 | Level-sensitive active-low load strobe, asynchronous to clk |
| clr_n | input | 1 | Active-low preset request, asserts asynchronously |
| half_sel | input | 1 | Preset select: 0 gives zero, 1 gives half-scale |
| dac_codes | output | 4*W | Output register codes, lane k for channel k |

## Verification
The bench builds the block with W = 4 and SYNC_STAGES = 2. At that width every code can be written to every channel in single-buffered mode, so the full code space of all four lanes is swept. The half-scale preset is a one-bit pattern that can be checked directly. Short synchronizers make the exact edge on which a load or a clear release takes effect easy to observe, so those cycle counts are checked precisely rather than only after a long wait.

// File: rtl/quad_dac_regbank_pkg.sv
package quad_dac_regbank_pkg;

    localparam int NUM_CH  = 4;
    localparam int CH_AW   = 2;
    localparam int MAX_W   = 32;

    typedef enum logic [1:0] {
        OUT_HOLD   = 2'd0,
        OUT_FOLLOW = 2'd1,
        OUT_PRESET = 2'd2
    } out_mode_e;

    typedef struct packed {
        logic             valid;
        logic [CH_AW-1:0] addr;
    } wr_ctl_t;

    // Preset pattern: zero, or only the top bit of a w-bit code set.
    function automatic logic [MAX_W-1:0] preset_word(input int w, input logic half);
        logic [MAX_W-1:0] r;
        r = '0;
        if (half) r[w-1] = 1'b1;
        return r;
    endfunction

    function automatic out_mode_e pick_mode(input logic preset, input logic follow);
        if (preset)      return OUT_PRESET;
        else if (follow) return OUT_FOLLOW;
        else             return OUT_HOLD;
    endfunction

endpackage

// File: rtl/quad_dac_regbank_sync.sv
module quad_dac_regbank_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_sync = chain[LAST];
endmodule

// File: rtl/quad_dac_regbank_clr.sv
module quad_dac_regbank_clr #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    output logic preset_act
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] hold;

    // Asserts as soon as clr_n falls; drains one stage per edge after release.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            hold <= '1;
        end else if (rst) begin
            hold <= '0;
        end else begin
            hold <= {hold[LAST:0], 1'b0} >> 0;
            hold[0] <= 1'b0;
            for (int i = 1; i < STAGES; i++) begin
                hold[i] <= hold[i-1];
            end
        end
    end

    assign preset_act = rst | hold[LAST];
endmodule

// File: rtl/quad_dac_regbank_stage.sv
module quad_dac_regbank_stage
    import quad_dac_regbank_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                     clk,
    input  logic                     preset_act,
    input  logic [W-1:0]             preset_val,
    input  wr_ctl_t                  wr_ctl,
    input  logic [W-1:0]             wr_data,
    output logic [NUM_CH-1:0][W-1:0] stage_q,
    output logic [NUM_CH-1:0][W-1:0] stage_d
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = wr_ctl.valid && (wr_ctl.addr == CH_AW'(c));

        always_comb begin
            if (preset_act)  stage_d[c] = preset_val;
            else if (hit)    stage_d[c] = wr_data;
            else             stage_d[c] = stage_q[c];
        end

        always_ff @(posedge clk) begin
            stage_q[c] <= stage_d[c];
        end
    end
endmodule

// File: rtl/quad_dac_regbank_out.sv
module quad_dac_regbank_out
    import quad_dac_regbank_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                     clk,
    input  logic                     preset_act,
    input  logic                     follow,
    input  logic [W-1:0]             preset_val,
    input  logic [NUM_CH-1:0][W-1:0] stage_d,
    output logic [NUM_CH-1:0][W-1:0] out_q
);
    out_mode_e mode;

    assign mode = pick_mode(preset_act, follow);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            unique case (mode)
                OUT_PRESET: out_q[c] <= preset_val;
                OUT_FOLLOW: out_q[c] <= stage_d[c];
                default:    out_q[c] <= out_q[c];
            endcase
        end
    end
endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
    import quad_dac_regbank_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid,
    input  logic [1:0]               wr_addr,
    input  logic [W-1:0]             wr_data,
    input  logic                     ldac_n,
    input  logic                     clr_n,
    input  logic                     half_sel,
    output logic [NUM_CH-1:0][W-1:0] dac_codes
);
    logic                     preset_act;
    logic                     ldac_sync;
    logic                     ld_active;
    logic [W-1:0]             preset_val;
    wr_ctl_t                  wr_ctl;
    logic [NUM_CH-1:0][W-1:0] inp_codes;
    logic [NUM_CH-1:0][W-1:0] inp_next;

    assign preset_val = W'(preset_word(W, half_sel));
    assign wr_ctl     = '{valid: wr_valid, addr: wr_addr};
    assign ld_active  = ~ldac_sync;

    quad_dac_regbank_clr #(.STAGES(SYNC_STAGES)) u_clr (
        .clk        (clk),
        .rst        (rst),
        .clr_n      (clr_n),
        .preset_act (preset_act)
    );

    quad_dac_regbank_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ldac_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (ldac_n),
        .q_sync  (ldac_sync)
    );

    quad_dac_regbank_stage #(.W(W)) u_stage (
        .clk        (clk),
        .preset_act (preset_act),
        .preset_val (preset_val),
        .wr_ctl     (wr_ctl),
        .wr_data    (wr_data),
        .stage_q    (inp_codes),
        .stage_d    (inp_next)
    );

    quad_dac_regbank_out #(.W(W)) u_out (
        .clk        (clk),
        .preset_act (preset_act),
        .follow     (ld_active),
        .preset_val (preset_val),
        .stage_d    (inp_next),
        .out_q      (dac_codes)
    );
endmodule

// File: rtl/quad_dac_regbank_chk.sv
module quad_dac_regbank_chk
    import quad_dac_regbank_pkg::*;
#(
    parameter int W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     preset_act,
    input logic                     ld_active,
    input logic                     wr_valid,
    input logic [1:0]               wr_addr,
    input logic                     half_sel,
    input logic [NUM_CH-1:0][W-1:0] inp_codes,
    input logic [NUM_CH-1:0][W-1:0] dac_codes
);
    localparam logic [W-1:0] HALF = W'(1) << (W - 1);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!preset_act && !ld_active) |=> $stable(dac_codes));

    assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
        (!preset_act && ld_active) |=> (dac_codes == inp_codes));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assert_only_addr_R3: assert property (@(posedge clk) disable iff (rst)
            (!preset_act && !(wr_valid && wr_addr == CH_AW'(c))) |=> $stable(inp_codes[c]));

        assert_preset_R7: assert property (@(posedge clk) disable iff (rst)
            preset_act |=> (dac_codes[c] == ($past(half_sel) ? HALF : '0)
                            && inp_codes[c] == dac_codes[c]));
    end
endmodule

bind quad_dac_regbank quad_dac_regbank_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .preset_act (preset_act),
    .ld_active  (ld_active),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .half_sel   (half_sel),
    .inp_codes  (inp_codes),
    .dac_codes  (dac_codes)
);

// File: tb/quad_dac_regbank_tb.sv
module quad_dac_regbank_tb;
    localparam int W    = 4;
    localparam int SYNC = 2;
    localparam int NCH  = 4;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  wr_valid;
    logic [1:0]            wr_addr;
    logic [W-1:0]          wr_data;
    logic                  ldac_n;
    logic                  clr_n;
    logic                  half_sel;
    logic [NCH-1:0][W-1:0] dac_codes;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [W-1:0] m_inp [NCH];
    logic [W-1:0] m_dac [NCH];

    always #5 clk = ~clk;

    quad_dac_regbank #(.W(W), .SYNC_STAGES(SYNC)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ldac_n    (ldac_n),
        .clr_n     (clr_n),
        .half_sel  (half_sel),
        .dac_codes (dac_codes)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic [W-1:0] pv(input logic h);
        return h ? W'(1 << (W - 1)) : '0;
    endfunction

    task automatic model_preset(input logic h);
        for (int c = 0; c < NCH; c++) begin
            m_inp[c] = pv(h);
            m_dac[c] = pv(h);
        end
    endtask

    task automatic check_all(input string tag);
        bit bad = 1'b0;
        n_checks++;
        for (int c = 0; c < NCH; c++) begin
            if (dac_codes[c] !== m_dac[c]) begin
                $display("FAIL %s lane %0d actual %h expected %h", tag, c, dac_codes[c], m_dac[c]);
                bad = 1'b1;
            end
        end
        if (bad) n_fails++;
    endtask

    // One write, one edge; the model follows when the load strobe is active.
    task automatic do_write(input int a, input logic [W-1:0] d, input bit loading);
        wr_valid = 1'b1;
        wr_addr  = 2'(a);
        wr_data  = d;
        tick();
        wr_valid = 1'b0;
        m_inp[a] = d;
        if (loading) m_dac[a] = d;
    endtask

    task automatic load_all();
        for (int c = 0; c < NCH; c++) m_dac[c] = m_inp[c];
    endtask

    initial begin
        rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        ldac_n = 1'b1; clr_n = 1'b1; half_sel = 1'b0;
        tick(3);
        rst = 1'b0;
        model_preset(1'b0);
        check_all("R1 power-on zero");

        for (int h = 0; h < 2; h++) begin
            half_sel = 1'(h);
            rst = 1'b1;
            tick();
            rst = 1'b0;
            tick();
            model_preset(1'(h));
            check_all("R1 R2 reset preset");
            tick(4);
            check_all("R8 preset kept with load high");
            ldac_n = 1'b0;
            tick(SYNC + 1);
            check_all("R8 load without write keeps preset");
            ldac_n = 1'b1;
            tick(SYNC + 1);
        end

        // Single-buffered sweep of every code on every channel.
        ldac_n = 1'b0;
        tick(SYNC + 1);
        for (int a = 0; a < NCH; a++) begin
            for (int d = 0; d < (1 << W); d++) begin
                do_write(a, W'(d), 1'b1);
                check_all("R6 single-buffered write");
            end
        end

        // Double-buffered staging.
        ldac_n = 1'b1;
        tick(SYNC + 1);
        for (int a = 0; a < NCH; a++) begin
            do_write(a, W'((a * 5 + 3) & 15), 1'b0);
            check_all("R3 R5 staged write holds outputs");
        end
        do_write(2, W'(6), 1'b0);
        check_all("R3 rewrite of one channel");
        ldac_n = 1'b0;
        tick(SYNC);
        check_all("R4 load not yet taken");
        tick();
        load_all();
        check_all("R4 all lanes load together");
        ldac_n = 1'b1;
        tick(SYNC + 1);
        do_write(0, W'(1), 1'b0);
        tick(3);
        check_all("R5 hold after load released");

        // Clear to half-scale.
        half_sel = 1'b1;
        clr_n = 1'b0;
        tick();
        model_preset(1'b1);
        check_all("R7 R2 clear to half-scale");
        do_write(1, W'(5), 1'b0);
        model_preset(1'b1);
        ldac_n = 1'b0;
        tick(SYNC + 1);
        check_all("R7 write and load ignored while clear low");
        clr_n = 1'b1;
        tick(SYNC);
        check_all("R7 still preset during release");
        do_write(3, W'(9), 1'b1);
        check_all("R7 write accepted after release");

        // Clear to zero.
        half_sel = 1'b0;
        clr_n = 1'b0;
        tick();
        clr_n = 1'b1;
        model_preset(1'b0);
        check_all("R7 R2 clear to zero");
        tick(SYNC);
        do_write(2, W'(11), 1'b1);
        check_all("R6 write after zero clear");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule